// File: doc/BRIEF.md
# Pairwise Stream Operator with Unload Handshake

This block sits between an upstream FIFO and a downstream FIFO and consumes its input two words at a time. A mode input selects the function that is currently loaded. The larger-value function emits one word per pair, the larger of the two. The order-reversal function emits both words of the pair, the later one first. The block never reads from an empty source, never writes to a full sink, and stalls in place whenever the sink fills, including between the two writes of a reversed pair.

A synchronization add-on answers an unload request from a reconfiguration controller. The acknowledge is given only at a pair boundary with every result written out. While the acknowledge is high, the block is frozen and takes nothing from the source. The acknowledge falls one cycle after the request is withdrawn, and normal operation then resumes. Reset discards any half-read pair, so nothing from an earlier mode or pair reaches the output.

The controller is a five-state machine. **IDLE** waits at a pair boundary. **GOT_FIRST** holds the first word. **WRITE_A** emits the primary result. **WRITE_B** emits the first word, and is used by the reversal mode only. **ACKED** holds the acknowledge. The transitions are:
- IDLE→ACKED on a request. The request has priority over reading.
- IDLE→GOT_FIRST on a read.
- GOT_FIRST→WRITE_A on the second read.
- WRITE_A→IDLE after the write in larger-value mode.
- WRITE_A→WRITE_B after the write in reversal mode.
- WRITE_B→IDLE after the write.
- ACKED→IDLE when the request is low.

Top module: `pair_stream_op`

## Requirements
- R1: With `mode`=0 (larger-value), each pair (first word A, second word B) yields exactly one output word, max(A,B), compared as unsigned 32-bit numbers. When A equals B, the output is A.
- R2: With `mode`=1 (reversal), each pair yields exactly two output words, B and then A.
- R3: `in_rd_en` is never high while `in_empty` is high, and `out_wr_en` is never high while `out_full` is high.
- R4: While `out_full` is high, the pending output word stays on `out_data` and no write occurs. This also holds between the two writes of a reversed pair.
- R5: A request (`unload_req`=1) seen at a pair boundary raises `unload_ack` one cycle later, and no new pair is started.
- R6: `unload_ack` stays low while a pair is half read or a result is still unwritten. It rises only after the last result has been written.
- R7: `unload_ack` stays high while `unload_req` stays high. It goes low one cycle after `unload_req` falls, and processing then resumes.
- R8: While `unload_ack` is high, no word is taken from the source FIFO, even when the source is not empty.
- R9: Reset (`rst_n`=0) discards a half-read pair and clears `unload_ack`, `in_rd_en` and `out_wr_en`. Output after reset depends only on words read after reset.
- R10: The mode is sampled when the first word of a pair is read. A change of `mode` in the middle of a pair does not affect that pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | 0 = larger-value, 1 = reversal |
| in_empty | input | 1 | Source FIFO has no word |
| in_data | input | 32 | Head word of source FIFO |
| in_rd_en | output | 1 | Consume head word this cycle |
| out_full | input | 1 | Sink FIFO cannot accept |
| out_wr_en | output | 1 | Write `out_data` this cycle |
| out_data | output | 32 | Result word |
| unload_req | input | 1 | Unload request from controller |
| unload_ack | output | 1 | Safe-to-unload acknowledge |

## Verification
A wrong internal state shows at the ports within a pair. A lost first word shifts every later pair, so the next output value is wrong. A wrong mode latch changes the number of words written per pair. An early exit from the machine raises `unload_ack` while the sink still lacks a result, which the count of written words exposes before the acknowledge is seen. A frozen state leaves `unload_ack` high after the request falls, or leaves words unread in the source, and both show within a few cycles.

// File: rtl/pso_pkg.sv
package pso_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_GOT_FIRST = 3'd1,
        ST_WRITE_A   = 3'd2,
        ST_WRITE_B   = 3'd3,
        ST_ACKED     = 3'd4
    } pso_state_t;

    typedef enum logic {
        MODE_MAX  = 1'b0,
        MODE_SWAP = 1'b1
    } pso_mode_t;
endpackage

// File: rtl/pso_ctrl.sv
module pso_ctrl
    import pso_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_empty,
    input  logic out_full,
    input  logic unload_req,
    input  logic pair_is_swap,
    output logic rd_en,
    output logic wr_en,
    output logic load_first,
    output logic load_second,
    output logic emit_first,
    output logic ack
);
    pso_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        rd_en       = 1'b0;
        wr_en       = 1'b0;
        load_first  = 1'b0;
        load_second = 1'b0;
        emit_first  = 1'b0;
        ack         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (unload_req) begin
                    state_d = ST_ACKED;
                end else if (!in_empty) begin
                    rd_en      = 1'b1;
                    load_first = 1'b1;
                    state_d    = ST_GOT_FIRST;
                end
            end
            ST_GOT_FIRST: begin
                if (!in_empty) begin
                    rd_en       = 1'b1;
                    load_second = 1'b1;
                    state_d     = ST_WRITE_A;
                end
            end
            ST_WRITE_A: begin
                if (!out_full) begin
                    wr_en   = 1'b1;
                    state_d = pair_is_swap ? ST_WRITE_B : ST_IDLE;
                end
            end
            ST_WRITE_B: begin
                emit_first = 1'b1;
                if (!out_full) begin
                    wr_en   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_ACKED: begin
                ack = 1'b1;
                if (!unload_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pso_datapath.sv
module pso_datapath
    import pso_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode,
    input  logic [W-1:0] in_data,
    input  logic         load_first,
    input  logic         load_second,
    input  logic         emit_first,
    output logic         pair_is_swap,
    output logic [W-1:0] result
);
    logic [W-1:0] first_q, second_q;
    pso_mode_t    mode_q;
    logic [W-1:0] primary;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
            mode_q   <= MODE_MAX;
        end else begin
            if (load_first) begin
                first_q <= in_data;
                mode_q  <= pso_mode_t'(mode);
            end
            if (load_second) second_q <= in_data;
        end
    end

    always_comb begin
        if (mode_q == MODE_SWAP)       primary = second_q;
        else if (second_q > first_q)   primary = second_q;
        else                           primary = first_q;
    end

    assign result       = emit_first ? first_q : primary;
    assign pair_is_swap = (mode_q == MODE_SWAP);
endmodule

// File: rtl/pair_stream_op.sv
module pair_stream_op
    import pso_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode,
    input  logic         in_empty,
    input  logic [W-1:0] in_data,
    output logic         in_rd_en,
    input  logic         out_full,
    output logic         out_wr_en,
    output logic [W-1:0] out_data,
    input  logic         unload_req,
    output logic         unload_ack
);
    logic load_first, load_second, emit_first, pair_is_swap;

    pso_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_empty    (in_empty),
        .out_full    (out_full),
        .unload_req  (unload_req),
        .pair_is_swap(pair_is_swap),
        .rd_en       (in_rd_en),
        .wr_en       (out_wr_en),
        .load_first  (load_first),
        .load_second (load_second),
        .emit_first  (emit_first),
        .ack         (unload_ack)
    );

    pso_datapath #(.W(W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .in_data     (in_data),
        .load_first  (load_first),
        .load_second (load_second),
        .emit_first  (emit_first),
        .pair_is_swap(pair_is_swap),
        .result      (out_data)
    );
endmodule

// File: rtl/pso_checker.sv
module pso_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_empty,
    input logic         in_rd_en,
    input logic         out_full,
    input logic         out_wr_en,
    input logic [W-1:0] out_data,
    input logic         unload_req,
    input logic         unload_ack
);
    AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd_en |-> !in_empty); // R3
    AST_NO_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> !out_full); // R3
    AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_full && $past(out_full) && !unload_ack && !$past(in_rd_en) && !in_rd_en && $past(rst_n)) |-> $stable(out_data)); // R4
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unload_ack) |-> $past(unload_req)); // R5
    AST_ACK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        unload_ack |-> !out_wr_en); // R6
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (unload_ack && unload_req) |=> unload_ack); // R7
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (unload_ack && !unload_req) |=> !unload_ack); // R7
    AST_ACK_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        unload_ack |-> !in_rd_en); // R8
endmodule

bind pair_stream_op pso_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_empty  (in_empty),
    .in_rd_en  (in_rd_en),
    .out_full  (out_full),
    .out_wr_en (out_wr_en),
    .out_data  (out_data),
    .unload_req(unload_req),
    .unload_ack(unload_ack)
);

// File: tb/sim_pair_stream_op.sv
`timescale 1ns/1ps
module sim_pair_stream_op;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        out_full = 1'b0;
    logic        unload_req = 1'b0;
    logic        in_rd_en, out_wr_en, unload_ack, in_empty;
    logic [31:0] out_data, in_data;

    logic [31:0] in_mem [0:127];
    logic [31:0] out_mem [0:127];
    int in_tail = 0;
    int in_head = 0;
    int out_cnt = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    assign in_empty = (in_head == in_tail);
    assign in_data  = in_empty ? 32'hDEAD_BEEF : in_mem[in_head[6:0]];

    always @(posedge clk) begin
        if (in_rd_en && !in_empty) in_head <= in_head + 1;
        if (out_wr_en && !out_full) begin
            out_mem[out_cnt[6:0]] <= out_data;
            out_cnt <= out_cnt + 1;
        end
    end

    pair_stream_op u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .in_empty(in_empty),
        .in_data(in_data), .in_rd_en(in_rd_en), .out_full(out_full),
        .out_wr_en(out_wr_en), .out_data(out_data),
        .unload_req(unload_req), .unload_ack(unload_ack)
    );

    localparam int NV = 8;
    // {mode, first word, second word}
    localparam logic [64:0] VEC [NV] = '{
        {1'b0, 32'd5,          32'd9},
        {1'b0, 32'd9,          32'd5},
        {1'b0, 32'h8000_0000,  32'd1},
        {1'b0, 32'd7,          32'd7},
        {1'b1, 32'h1111_1111,  32'h2222_2222},
        {1'b1, 32'hFFFF_FFFF,  32'd0},
        {1'b0, 32'd0,          32'hFFFF_FFFF},
        {1'b1, 32'd3,          32'd3}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        in_mem[in_tail[6:0]] = w;
        in_tail = in_tail + 1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_out(input int n);
        for (int k = 0; k < 200 && out_cnt < n; k++) @(negedge clk);
    endtask

    initial begin
        #500000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        logic [31:0] a, b, e;
        cyc(3);
        chk(!unload_ack && !in_rd_en && !out_wr_en, "R9 reset outputs low", {29'd0, unload_ack, in_rd_en, out_wr_en}, 32'd0);
        rst_n = 1'b1;
        cyc(1);

        // table walk: R1 larger-value, R2 reversal
        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][64];
            a = VEC[i][63:32];
            b = VEC[i][31:0];
            base = out_cnt;
            push(a);
            push(b);
            if (!mode) begin
                e = (b > a) ? b : a;
                wait_out(base + 1);
                cyc(3);
                chk(out_cnt == base + 1, "R1 one word per pair", out_cnt - base, 32'd1);
                chk(out_mem[base[6:0]] == e, "R1 unsigned max", out_mem[base[6:0]], e);
            end else begin
                wait_out(base + 2);
                cyc(3);
                chk(out_cnt == base + 2, "R2 two words per pair", out_cnt - base, 32'd2);
                chk(out_mem[base[6:0]] == b, "R2 second word first", out_mem[base[6:0]], b);
                chk(out_mem[base[6:0] + 7'd1] == a, "R2 first word last", out_mem[base[6:0] + 7'd1], a);
            end
        end

        // R4 stall between reversal writes, R3 no write while full
        mode = 1'b1;
        out_full = 1'b1;
        base = out_cnt;
        push(32'hAAAA_0001);
        push(32'hBBBB_0002);
        cyc(5);
        chk(out_cnt == base && !out_wr_en, "R3 no write while full", out_cnt - base, 32'd0);
        chk(out_data == 32'hBBBB_0002, "R4 pending word held", out_data, 32'hBBBB_0002);
        out_full = 1'b0;
        cyc(1);
        out_full = 1'b1;
        cyc(4);
        chk(out_cnt == base + 1, "R4 one write then stall", out_cnt - base, 32'd1);
        chk(out_data == 32'hAAAA_0001, "R4 second word held while full", out_data, 32'hAAAA_0001);
        out_full = 1'b0;
        wait_out(base + 2);
        chk(out_mem[base[6:0] + 7'd1] == 32'hAAAA_0001, "R4 resumed write", out_mem[base[6:0] + 7'd1], 32'hAAAA_0001);

        // R6 ack waits for pending result
        mode = 1'b0;
        out_full = 1'b1;
        base = out_cnt;
        push(32'd40);
        push(32'd50);
        cyc(4);
        unload_req = 1'b1;
        cyc(4);
        chk(!unload_ack, "R6 no ack with result pending", {31'd0, unload_ack}, 32'd0);
        out_full = 1'b0;
        cyc(3);
        chk(unload_ack == 1'b1, "R6 ack after drain", {31'd0, unload_ack}, 32'd1);
        chk(out_cnt == base + 1 && out_mem[base[6:0]] == 32'd50, "R6 result written before ack", out_mem[base[6:0]], 32'd50);

        // R8 frozen while acked, R7 held then released
        base = in_head;
        push(32'd11);
        push(32'd3);
        cyc(5);
        chk(in_head == base, "R8 no read while acked", in_head - base, 32'd0);
        chk(unload_ack == 1'b1, "R7 ack held with req", {31'd0, unload_ack}, 32'd1);
        unload_req = 1'b0;
        cyc(1);
        chk(!unload_ack, "R7 ack falls after req", {31'd0, unload_ack}, 32'd0);
        base = out_cnt;
        wait_out(base + 1);
        chk(out_mem[base[6:0]] == 32'd11, "R7 resumes after release", out_mem[base[6:0]], 32'd11);

        // R5 req at boundary: ack next cycle
        cyc(2);
        unload_req = 1'b1;
        cyc(1);
        chk(unload_ack == 1'b1, "R5 ack one cycle after req", {31'd0, unload_ack}, 32'd1);
        unload_req = 1'b0;
        cyc(2);

        // R10 mode sampled at first word
        mode = 1'b0;
        base = out_cnt;
        push(32'd2);
        cyc(3);
        mode = 1'b1;
        push(32'd8);
        wait_out(base + 1);
        cyc(4);
        chk(out_cnt == base + 1 && out_mem[base[6:0]] == 32'd8, "R10 mode change mid-pair ignored", out_cnt - base, 32'd1);

        // R9 reset discards half pair
        mode = 1'b0;
        push(32'hFFFF_0000);
        cyc(3);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        base = out_cnt;
        push(32'd4);
        push(32'd6);
        wait_out(base + 1);
        cyc(4);
        chk(out_cnt == base + 1 && out_mem[base[6:0]] == 32'd6, "R9 clean after reset", out_mem[base[6:0]], 32'd6);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule